// File: doc/BRIEF.md
# Symbol Timing Interpolation Controller

This block decides when a symbol timing recovery loop takes its interpolated samples. It runs at the input sample rate and keeps a phase register that holds an unsigned fraction in [0,1). On each valid input sample the register is decreased by a step and wraps modulo 1. The step is a nominal value of 1/N, where N is the number of samples per symbol, plus a signed correction word from an external loop filter. When a decrement takes the phase below zero, the block raises a strobe. That strobe is the recovered symbol clock. It tells the interpolator that the current sample period holds an optimal sampling instant.

Each strobe comes with a fractional interval that places that instant between two input samples. The interval is the phase value just before the wrap divided by the step. The division is approximated as phase·N·(2 − step·N), with no divider in the path. A positive correction word makes the strobes come faster, so the loop can pull a late clock forward. A negative correction word slows the strobes, so the loop can hold back an early clock. When the correction word returns to zero, the strobes return to the nominal rate of one per N samples.

Top module: `symclk_nco`

## Requirements
- R1: A synchronous reset clears `strobe` and `frac` to 0 and loads the phase with 0.5 (0x8000 at W=16). With N=4 and a zero correction word, the first strobe therefore follows the third valid sample.
- R2: The step equals floor(2^W/N) plus the signed correction word. With a zero correction word, the strobe occurs once every N valid samples.
- R3: The step is clamped to the range from floor(2^W/N)/2 to 2·floor(2^W/N), which is 1/(2N) to 2/N. Correction words of 0x7FFF and 0x8000 give the same strobe rate as the upper bound and the lower bound.
- R4: A wrap happens when the phase is strictly below the step. A valid sample that wraps sets `strobe` to 1 on the following clock edge, and a valid sample that does not wrap sets it to 0.
- R5: The number of strobes in a run of valid samples grows with the step: at N=4 over 40 samples from reset, the count is 12 for a correction word of +0x1000, 15 for +0x2000 and 7 for −0x1000.
- R6: While `in_valid` is low, the phase does not advance and `strobe` and `frac` keep their values. A strobe therefore lasts for exactly one valid sample.
- R7: On a wrap, `frac` (unsigned Q0.W) becomes floor(p·N·(2·2^W − step·N) / 2^W), where p is the phase before the wrap, saturated to 2^W−1. Between wraps `frac` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High on cycles that carry an input sample |
| ctrl_word | input | W | Signed Q0.W correction word from the loop filter |
| strobe | output | 1 | Interpolation strobe, the recovered symbol clock |
| frac | output | W | Unsigned Q0.W fractional interval for the interpolator |

## Verification
The bench builds the block with W=16 and N=4. With these values the nominal step is exactly 0x4000, and the strobe counts over 40 samples from the 0x8000 start can be worked out by hand. Both clamp bounds (0x2000 and 0x8000) can be reached with the full-scale correction words. With N=4, the reciprocal approximation gives exact, easily derived intervals, such as 0x9000 for a step of 0x5000 and 0xA000 for a step of 0x3000. Gaps in `in_valid` are placed around a strobe so that its hold behaviour can be seen at the ports.

// File: rtl/symclk_nco.sv
module symclk_nco #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] ctrl_word,
  output logic                strobe,
  output logic [W-1:0]        frac
);
  localparam int PW = 2*W + 8;
  localparam int NOMI = (1 << W) / N;
  localparam logic signed [W+2:0] NOM  = (W+3)'(NOMI);
  localparam logic signed [W+2:0] SMIN = (W+3)'(NOMI / 2);
  localparam logic signed [W+2:0] SMAX = (W+3)'(2 * NOMI);

  logic [W-1:0]        phase;
  logic signed [W+2:0] raw;
  logic [W:0]          step;
  logic                uflow;
  logic [PW-1:0]       scaled, recip, prod;
  logic [W-1:0]        mu;

  assign raw   = NOM + {{3{ctrl_word[W-1]}}, ctrl_word};
  assign step  = (raw < SMIN) ? SMIN[W:0] : (raw > SMAX) ? SMAX[W:0] : raw[W:0];
  assign uflow = {1'b0, phase} < step;

  assign scaled = PW'(step) * PW'(N);
  assign recip  = (PW'(2) << W) - scaled;
  assign prod   = ((PW'(phase) * PW'(N)) * recip) >> W;
  assign mu     = (prod >= (PW'(1) << W)) ? '1 : prod[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= {1'b1, {(W-1){1'b0}}};
      strobe <= 1'b0;
      frac   <= '0;
    end else if (in_valid) begin
      phase  <= phase - step[W-1:0];
      strobe <= uflow;
      if (uflow) frac <= mu;
    end
  end
endmodule

module symclk_nco_chk #(
  parameter int W = 16,
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         strobe,
  input logic [W-1:0] frac,
  input logic [W:0]   step
);
  localparam int NOMI = (1 << W) / N;

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!strobe && frac == '0));

  a_r3_step_range: assert property (@(posedge clk) disable iff (rst)
    (int'(step) >= NOMI / 2) && (int'(step) <= 2 * NOMI));

  a_r4_strobe_from_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> $past(in_valid));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(strobe) && $stable(frac)));

  a_r7_frac_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(frac) |-> strobe);
endmodule

bind symclk_nco symclk_nco_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .strobe(strobe), .frac(frac), .step(step)
);

// File: tb/tb_symclk_nco.sv
module tb_symclk_nco;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic signed [15:0] ctrl_word = '0;
  logic        strobe;
  logic [15:0] frac;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  symclk_nco #(.W(16), .N(4)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl_word(ctrl_word),
    .strobe(strobe), .frac(frac)
  );

  always #4 clk = ~clk;

  // ctrl word, valid samples, expected strobe count (N=4, from reset)
  localparam logic [47:0] VEC [6] = '{
    {16'h0000, 16'd40, 16'd10},
    {16'h1000, 16'd40, 16'd12},
    {16'h2000, 16'd40, 16'd15},
    {16'hF000, 16'd40, 16'd7},
    {16'h7FFF, 16'd40, 16'd20},
    {16'h8000, 16'd40, 16'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    in_valid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [15:0] c);
    rst = 1'b1;
    ctrl_word = c;
    tick(1'b0);
    tick(1'b0);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    do_reset(16'h0000);
    check("R1 reset strobe", strobe, 0);
    check("R1 reset frac", frac, 0);

    for (int k = 1; k <= 12; k++) begin
      tick(1'b1);
      check("R2 R4 nominal strobe pattern", strobe, (k % 4 == 3) ? 1 : 0);
    end

    for (int i = 0; i < 6; i++) begin
      do_reset(VEC[i][47:32]);
      cnt = 0;
      for (int k = 0; k < int'(VEC[i][31:16]); k++) begin
        tick(1'b1);
        if (strobe) cnt++;
      end
      check(i >= 4 ? "R3 clamped strobe count" : "R5 strobe count", cnt, VEC[i][15:0]);
    end

    do_reset(16'h0000);
    tick(1'b1); tick(1'b1); tick(1'b1);
    check("R1 first strobe on third sample", strobe, 1);
    for (int k = 0; k < 3; k++) begin
      tick(1'b0);
      check("R6 strobe held while idle", strobe, 1);
    end
    check("R6 frac held while idle", frac, 0);
    tick(1'b1);
    check("R6 strobe cleared on next valid", strobe, 0);
    tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b1);
    check("R6 phase frozen during gaps", strobe, 0);
    tick(1'b1);
    check("R6 next strobe after four valid samples", strobe, 1);

    do_reset(16'h1000);
    tick(1'b1);
    check("R4 no wrap first sample", strobe, 0);
    tick(1'b1);
    check("R4 wrap strobe", strobe, 1);
    check("R7 frac step 0x5000", frac, 16'h9000);
    tick(1'b1);
    check("R7 frac held between strobes", frac, 16'h9000);

    do_reset(16'hF000);
    tick(1'b1); tick(1'b1); tick(1'b1);
    check("R4 wrap strobe slow step", strobe, 1);
    check("R7 frac step 0x3000", frac, 16'hA000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule